// File: doc/BRIEF.md
# Transposable Selective ARQ Receive Buffer

This block sits at the receiving end of a link that protects traffic with a two-dimensional parity code. A group of L data flits arrives, followed by one parity flit that is the bitwise XOR of those flits. Each flit also carries its own even-parity bit. The buffer stores the whole group. It then derives two syndromes: one check bit per flit, and one check bit per bit position across all stored flits (the column check). From these it either releases the group or asks the sender for a repair.

A single flipped bit is corrected in place with no request. When no flit check is set but some bit positions fail (two flips in one flit), the buffer issues row requests, one bit index at a time. The reply vector is written down that bit column of every stored flit, including the parity flit. When exactly one flit fails with several bad positions, it asks for that flit again. When the pattern cannot be localised, or a repair does not clear the checks, it asks for the whole group again. That go-back request is also issued without storing anything when the configured group length exceeds the buffer's capacity. The group is released to the reader only after every outstanding request has been resolved.

Top module: `ppc_arq_buffer`

## Requirements
- R1: A flit is `{parity, data}`, with the parity bit at position DATA_W chosen so the flit XORs to zero. The flits of a group are written in order to rows 0..L-1 and the parity flit to row L. L is taken from `grp_len` at the first write of a group; 0 counts as 1.
- R2: If no flit check and no column bit is set, no request is issued. The L data fields are then presented on `rd_data` in row order while `rd_valid` is high, advancing one row per cycle with `rd_ack`. The data is held while `rd_ack` is low.
- R3: If exactly one flit check is set and exactly one column bit is set, that bit is inverted in place and the group is read out with no request.
- R4: If no flit check is set and the column check is nonzero, the block issues row requests (`arq_kind` 0), one for every failing bit index, in ascending order. The next request follows only after the reply to the previous one.
- R5: Bit r of a row reply (`rw_vec`, r < L) replaces bit j of row r, bit L replaces bit j of the parity flit, and bits above L are ignored; j is the requested bit index.
- R6: If exactly one flit check is set and more than one column bit is set, a column request (`arq_kind` 1) with that flit's row index is issued. The next flit write replaces that row.
- R7: After all replies, both checks are evaluated again. If any bit is still set, a go-back request (`arq_kind` 2, index 0) is issued and the buffer waits for a complete new group.
- R8: More than one flit check set, or one flit check set with a zero column check, leads straight to a go-back request.
- R9: If L exceeds BUF_FLITS, no flit is stored. A go-back request is issued after the parity flit's write.
- R10: `rd_valid` stays low from the first write of a group until the group is released, and in particular while any request is outstanding.
- R11: Flit writes are ignored except while filling or while awaiting a column reply. Row replies are ignored except while awaiting one.
- R12: `arq_valid` is a single-cycle pulse per request, and `arq_kind` never takes the value 3. After reset, `arq_valid` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_len | input | LEN_W | Flits per group, sampled at the first write |
| wr_valid | input | 1 | Flit write strobe |
| wr_flit | input | DATA_W+1 | Flit with parity bit on top |
| rw_valid | input | 1 | Row reply strobe |
| rw_vec | input | BUF_FLITS+1 | Row reply: one bit per stored row |
| arq_valid | output | 1 | Request pulse |
| arq_kind | output | 2 | 0 row, 1 column, 2 go-back |
| arq_idx | output | IDX_W | Bit index or flit index |
| rd_ack | input | 1 | Reader accepts the current flit |
| rd_valid | output | 1 | Released group flit available |
| rd_data | output | DATA_W | Data field of the current flit |

## Verification
The bound checker covers properties that hold on every cycle. Requests are single-cycle pulses with a legal kind. Row indices rise within a repair sequence and stay inside the flit width. Column and go-back indices are in range. The read side is quiet after a request and holds its data while not acknowledged. Whether the right request is chosen for a given flip pattern can only be shown by the bench's scenarios, which write groups with crafted flips and compare the requests and the released data against values computed from the code. The same applies to whether a column rewrite lands in the right bits, and to whether stale inputs are ignored.

// File: rtl/ppc_arq_pkg.sv
package ppc_arq_pkg;

    typedef enum logic [3:0] {
        ST_FILL     = 4'd0,
        ST_CHECK    = 4'd1,
        ST_ROW_REQ  = 4'd2,
        ST_ROW_WAIT = 4'd3,
        ST_COL_REQ  = 4'd4,
        ST_COL_WAIT = 4'd5,
        ST_RECHECK  = 4'd6,
        ST_GB_REQ   = 4'd7,
        ST_READ     = 4'd8
    } buf_state_e;

    localparam logic [1:0] KIND_ROW    = 2'd0;
    localparam logic [1:0] KIND_COL    = 2'd1;
    localparam logic [1:0] KIND_GOBACK = 2'd2;

endpackage

// File: rtl/ppc_syndrome.sv
// Flit checks and column check over the live rows 0..len of the grid.
module ppc_syndrome #(
    parameter int ROWS   = 9,
    parameter int FLIT_W = 17,
    parameter int LEN_W  = 5
) (
    input  logic [ROWS-1:0][FLIT_W-1:0] grid,
    input  logic [LEN_W-1:0]            len,
    output logic [ROWS-1:0]             flit_chk,
    output logic [FLIT_W-1:0]           col_chk
);

    logic [ROWS-1:0] live;

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            assign live[r]     = (32'(r) <= 32'(len));
            assign flit_chk[r] = live[r] & (^grid[r]);
        end
    endgenerate

    always_comb begin
        col_chk = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (live[r]) col_chk = col_chk ^ grid[r];
        end
    end

endmodule

// File: rtl/ppc_lowbit.sv
// Index of the lowest set bit of a vector, plus a nonzero flag.
module ppc_lowbit #(
    parameter int W  = 17,
    parameter int IW = 5
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ppc_arq_buffer.sv
module ppc_arq_buffer
    import ppc_arq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BUF_FLITS = 8,
    parameter int LEN_W     = 5,
    localparam int FLIT_W   = DATA_W + 1,
    localparam int ROWS     = BUF_FLITS + 1,
    localparam int IDX_W    = $clog2((FLIT_W > ROWS) ? FLIT_W : ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEN_W-1:0]  grp_len,
    input  logic              wr_valid,
    input  logic [DATA_W:0]   wr_flit,
    input  logic              rw_valid,
    input  logic [BUF_FLITS:0] rw_vec,
    output logic              arq_valid,
    output logic [1:0]        arq_kind,
    output logic [IDX_W-1:0]  arq_idx,
    input  logic              rd_ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    localparam int RIW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int CIW = $clog2(FLIT_W);

    typedef struct packed {
        buf_state_e                  st;
        logic [ROWS-1:0][FLIT_W-1:0] grid;
        logic [LEN_W:0]              cnt;
        logic [LEN_W-1:0]            len;
        logic [FLIT_W-1:0]           pend;
        logic [IDX_W-1:0]            idx;
        logic [RIW-1:0]              rptr;
    } ctl_t;

    ctl_t q, d;

    logic [ROWS-1:0]   flit_chk;
    logic [FLIT_W-1:0] col_chk;
    logic [RIW-1:0]    cf_low;
    logic              cf_any;
    logic [CIW-1:0]    cp_low;
    logic              cp_any;
    logic [FLIT_W-1:0] pend_after;
    logic [CIW-1:0]    pend_low;
    logic              pend_any;
    logic [LEN_W-1:0]  len_now;
    logic              overflow;
    logic              last_wr;
    logic              grp_clean;

    ppc_syndrome #(.ROWS(ROWS), .FLIT_W(FLIT_W), .LEN_W(LEN_W)) u_syn (
        .grid     (q.grid),
        .len      (q.len),
        .flit_chk (flit_chk),
        .col_chk  (col_chk)
    );

    ppc_lowbit #(.W(ROWS), .IW(RIW)) u_cf_low (
        .vec (flit_chk),
        .idx (cf_low),
        .any (cf_any)
    );

    ppc_lowbit #(.W(FLIT_W), .IW(CIW)) u_cp_low (
        .vec (col_chk),
        .idx (cp_low),
        .any (cp_any)
    );

    ppc_lowbit #(.W(FLIT_W), .IW(CIW)) u_pend_low (
        .vec (pend_after),
        .idx (pend_low),
        .any (pend_any)
    );

    assign pend_after = q.pend & ~(FLIT_W'(1) << q.idx);
    assign len_now    = (q.cnt == '0) ? ((grp_len == '0) ? LEN_W'(1) : grp_len) : q.len;
    assign overflow   = 32'(len_now) > BUF_FLITS;
    assign last_wr    = (q.cnt == {1'b0, len_now});
    assign grp_clean  = !cf_any && !cp_any;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_FILL: begin
                if (wr_valid) begin
                    if (q.cnt == '0) d.len = len_now;
                    for (int r = 0; r < ROWS; r++) begin
                        if (!overflow && q.cnt == (LEN_W+1)'(r)) d.grid[r] = wr_flit;
                    end
                    if (last_wr) begin
                        d.cnt = '0;
                        d.st  = overflow ? ST_GB_REQ : ST_CHECK;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_CHECK: begin
                if (grp_clean) begin
                    d.rptr = '0;
                    d.st   = ST_READ;
                end else if (!cf_any) begin
                    d.pend = col_chk;
                    d.idx  = IDX_W'(cp_low);
                    d.st   = ST_ROW_REQ;
                end else if ($countones(flit_chk) == 1 && cp_any) begin
                    if ($countones(col_chk) == 1) begin
                        d.grid[cf_low][cp_low] = ~q.grid[cf_low][cp_low];
                        d.rptr = '0;
                        d.st   = ST_READ;
                    end else begin
                        d.idx = IDX_W'(cf_low);
                        d.st  = ST_COL_REQ;
                    end
                end else begin
                    d.st = ST_GB_REQ;
                end
            end
            ST_ROW_REQ: d.st = ST_ROW_WAIT;
            ST_ROW_WAIT: begin
                if (rw_valid) begin
                    for (int r = 0; r < ROWS; r++) begin
                        for (int b = 0; b < FLIT_W; b++) begin
                            if (32'(r) <= 32'(q.len) && q.idx == IDX_W'(b)) d.grid[r][b] = rw_vec[r];
                        end
                    end
                    d.pend = pend_after;
                    if (pend_any) begin
                        d.idx = IDX_W'(pend_low);
                        d.st  = ST_ROW_REQ;
                    end else begin
                        d.st = ST_RECHECK;
                    end
                end
            end
            ST_COL_REQ: d.st = ST_COL_WAIT;
            ST_COL_WAIT: begin
                if (wr_valid) begin
                    for (int r = 0; r < ROWS; r++) begin
                        if (q.idx == IDX_W'(r)) d.grid[r] = wr_flit;
                    end
                    d.st = ST_RECHECK;
                end
            end
            ST_RECHECK: begin
                d.rptr = '0;
                d.st   = grp_clean ? ST_READ : ST_GB_REQ;
            end
            ST_GB_REQ: begin
                d.cnt = '0;
                d.st  = ST_FILL;
            end
            ST_READ: begin
                if (rd_ack) begin
                    if (32'(q.rptr) + 1 >= 32'(q.len)) begin
                        d.rptr = '0;
                        d.st   = ST_FILL;
                    end else begin
                        d.rptr = q.rptr + 1'b1;
                    end
                end
            end
            default: d.st = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_FILL;
        end else begin
            q <= d;
        end
    end

    assign arq_valid = (q.st == ST_ROW_REQ) || (q.st == ST_COL_REQ) || (q.st == ST_GB_REQ);
    assign arq_kind  = (q.st == ST_COL_REQ) ? KIND_COL :
                       (q.st == ST_GB_REQ)  ? KIND_GOBACK : KIND_ROW;
    assign arq_idx   = (q.st == ST_GB_REQ) ? '0 : q.idx;
    assign rd_valid  = (q.st == ST_READ);
    assign rd_data   = q.grid[q.rptr][DATA_W-1:0];

endmodule

// File: rtl/ppc_arq_checker.sv
module ppc_arq_checker #(
    parameter int DATA_W    = 16,
    parameter int BUF_FLITS = 8,
    parameter int LEN_W     = 5,
    localparam int FLIT_W   = DATA_W + 1,
    localparam int ROWS     = BUF_FLITS + 1,
    localparam int IDX_W    = $clog2((FLIT_W > ROWS) ? FLIT_W : ROWS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arq_valid,
    input logic [1:0]        arq_kind,
    input logic [IDX_W-1:0]  arq_idx,
    input logic              rd_ack,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data
);

    logic             row_seen_q;
    logic [IDX_W-1:0] last_row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_seen_q <= 1'b0;
            last_row_q <= '0;
        end else if (arq_valid) begin
            row_seen_q <= (arq_kind == 2'd0);
            last_row_q <= arq_idx;
        end else if (rd_valid) begin
            row_seen_q <= 1'b0;
        end
    end

    assert_arq_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arq_valid |=> !arq_valid) else $error("request held longer than one cycle");

    assert_kind_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arq_valid |-> arq_kind != 2'd3) else $error("illegal request kind");

    assert_row_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arq_valid && arq_kind == 2'd0 && row_seen_q) |-> arq_idx > last_row_q)
        else $error("row requests not ascending");

    assert_row_idx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arq_valid && arq_kind == 2'd0) |-> 32'(arq_idx) < FLIT_W)
        else $error("row index outside flit");

    assert_col_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (arq_valid && arq_kind == 2'd1) |-> 32'(arq_idx) <= BUF_FLITS)
        else $error("column index outside buffer");

    assert_goback_idx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (arq_valid && arq_kind == 2'd2) |-> arq_idx == '0)
        else $error("go-back index not zero");

    assert_quiet_after_arq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arq_valid |=> !rd_valid) else $error("read offered while request outstanding");

    assert_read_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ack) |=> (rd_valid && $stable(rd_data)))
        else $error("read data dropped without acknowledge");

endmodule

bind ppc_arq_buffer ppc_arq_checker #(
    .DATA_W(DATA_W), .BUF_FLITS(BUF_FLITS), .LEN_W(LEN_W)
) i_ppc_chk (
    .clk(clk), .rst_n(rst_n), .arq_valid(arq_valid), .arq_kind(arq_kind),
    .arq_idx(arq_idx), .rd_ack(rd_ack), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/test_ppc_arq_buffer.sv
module test_ppc_arq_buffer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  grp_len = 5'd4;
    logic        wr_valid = 1'b0;
    logic [16:0] wr_flit = '0;
    logic        rw_valid = 1'b0;
    logic [8:0]  rw_vec = '0;
    logic        arq_valid;
    logic [1:0]  arq_kind;
    logic [4:0]  arq_idx;
    logic        rd_ack = 1'b0;
    logic        rd_valid;
    logic [15:0] rd_data;

    always #10 clk = ~clk;

    ppc_arq_buffer i_ppc_arq_buffer (
        .clk(clk), .rst_n(rst_n), .grp_len(grp_len), .wr_valid(wr_valid),
        .wr_flit(wr_flit), .rw_valid(rw_valid), .rw_vec(rw_vec),
        .arq_valid(arq_valid), .arq_kind(arq_kind), .arq_idx(arq_idx),
        .rd_ack(rd_ack), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [6:0]  exp_arq_q[$];
    string       arq_tag_q[$];
    logic [15:0] exp_rd_q[$];
    string       rd_tag_q[$];

    logic [16:0] clean [0:15];
    logic [16:0] tx    [0:15];
    int          g_len;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected items as the design produces them.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (arq_valid) begin
                if (exp_arq_q.size() == 0) check(0, "R4", "unexpected request", {25'd0, arq_kind, arq_idx}, 0);
                else begin
                    logic [6:0] e;
                    string t;
                    e = exp_arq_q.pop_front();
                    t = arq_tag_q.pop_front();
                    check({arq_kind, arq_idx} == e, t, "request", {25'd0, arq_kind, arq_idx}, {25'd0, e});
                end
            end
            if (rd_valid && rd_ack) begin
                if (exp_rd_q.size() == 0) check(0, "R2", "unexpected read", {16'd0, rd_data}, 0);
                else begin
                    logic [15:0] e;
                    string t;
                    e = exp_rd_q.pop_front();
                    t = rd_tag_q.pop_front();
                    check(rd_data == e, t, "read data", {16'd0, rd_data}, {16'd0, e});
                end
            end
        end
    end

    function automatic logic [16:0] mkflit(input logic [15:0] dat);
        return {^dat, dat};
    endfunction

    task automatic build(input int len, input int seed);
        logic [16:0] p;
        p = '0;
        g_len = len;
        for (int i = 0; i < len; i++) begin
            clean[i] = mkflit(16'(seed * 15133 + i * 2741 + 77));
            p = p ^ clean[i];
        end
        clean[len] = p;
        for (int i = 0; i <= len; i++) tx[i] = clean[i];
        @(posedge clk); #2;
        grp_len = 5'(len);
    endtask

    task automatic push_arq(input logic [1:0] k, input int idx, input string tag);
        exp_arq_q.push_back({k, 5'(idx)});
        arq_tag_q.push_back(tag);
    endtask

    task automatic push_reads(input string tag);
        for (int i = 0; i < g_len; i++) begin
            exp_rd_q.push_back(clean[i][15:0]);
            rd_tag_q.push_back(tag);
        end
    endtask

    task automatic send_tx();
        for (int i = 0; i <= g_len; i++) begin
            @(posedge clk); #2;
            wr_valid = 1'b1;
            wr_flit  = tx[i];
        end
        @(posedge clk); #2;
        wr_valid = 1'b0;
    endtask

    // Waits for a request; then checks that nothing else is offered meanwhile.
    task automatic wait_arq(input string tag);
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!arq_valid && n < 300);
        check(arq_valid, tag, "request seen", 32'(arq_valid), 1);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check(!rd_valid && !arq_valid, "R10", "quiet while outstanding", {rd_valid, arq_valid}, 0);
        end
    endtask

    task automatic reply_row(input int j, input bit from_tx);
        logic [8:0] v;
        for (int r = 0; r < 9; r++) v[r] = (r <= g_len) ? (from_tx ? tx[r][j] : clean[r][j]) : 1'b1;
        @(posedge clk); #2;
        rw_valid = 1'b1;
        rw_vec   = v;
        @(posedge clk); #2;
        rw_valid = 1'b0;
    endtask

    task automatic read_all();
        int n;
        n = 0;
        @(posedge clk); #2;
        rd_ack = 1'b1;
        while (exp_rd_q.size() > 0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        @(posedge clk); #2;
        rd_ack = 1'b0;
        check(exp_rd_q.size() == 0, "R2", "all reads delivered", exp_rd_q.size(), 0);
    endtask

    task automatic wait_rd();
        int n;
        n = 0;
        while (!rd_valid && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check(!arq_valid && !rd_valid, "R12", "reset outputs", {arq_valid, rd_valid}, 0);

        // R11: a row reply while filling is ignored; R1/R2 clean group
        @(posedge clk); #2; rw_valid = 1'b1; rw_vec = 9'h1ff;
        @(posedge clk); #2; rw_valid = 1'b0;
        build(4, 1);
        push_reads("R2");
        send_tx();
        wait_rd();
        // R11: flit writes during read-out are ignored
        @(posedge clk); #2; wr_valid = 1'b1; wr_flit = 17'h1ffff;
        @(posedge clk); #2; wr_valid = 1'b0;
        read_all();

        // R3: single flip corrected in place
        build(4, 2);
        tx[2] = tx[2] ^ 17'(1 << 5);
        push_reads("R3");
        send_tx();
        wait_rd();
        read_all();

        // R4/R5: two flips in one flit -> row requests 3 then 9
        build(5, 3);
        tx[1] = tx[1] ^ 17'((1 << 3) | (1 << 9));
        push_arq(2'd0, 3, "R4");
        push_arq(2'd0, 9, "R4");
        push_reads("R5");
        send_tx();
        wait_arq("R4");
        reply_row(3, 0);
        wait_arq("R4");
        reply_row(9, 0);
        wait_rd();
        read_all();

        // R4: ascending order regardless of position (bits 12 and 2)
        build(3, 4);
        tx[2] = tx[2] ^ 17'((1 << 12) | (1 << 2));
        push_arq(2'd0, 2, "R4");
        push_arq(2'd0, 12, "R4");
        push_reads("R4");
        send_tx();
        wait_arq("R4");
        reply_row(2, 0);
        wait_arq("R4");
        reply_row(12, 0);
        wait_rd();
        read_all();

        // R6: three flips in flit 0 -> column request
        build(4, 5);
        tx[0] = tx[0] ^ 17'((1 << 1) | (1 << 2) | (1 << 4));
        push_arq(2'd1, 0, "R6");
        push_reads("R6");
        send_tx();
        wait_arq("R6");
        @(posedge clk); #2; wr_valid = 1'b1; wr_flit = clean[0];
        @(posedge clk); #2; wr_valid = 1'b0;
        wait_rd();
        read_all();

        // R8: flips in two flits -> go-back, then resend clean
        build(4, 6);
        tx[0] = tx[0] ^ 17'(1 << 1);
        tx[2] = tx[2] ^ 17'(1 << 7);
        push_arq(2'd2, 0, "R8");
        send_tx();
        wait_arq("R8");
        for (int i = 0; i <= g_len; i++) tx[i] = clean[i];
        push_reads("R8");
        send_tx();
        wait_rd();
        read_all();

        // R7: a corrupt row reply fails the re-check -> go-back
        build(4, 7);
        tx[1] = tx[1] ^ 17'((1 << 3) | (1 << 9));
        push_arq(2'd0, 3, "R7");
        push_arq(2'd0, 9, "R7");
        push_arq(2'd2, 0, "R7");
        send_tx();
        wait_arq("R7");
        reply_row(3, 0);
        wait_arq("R7");
        reply_row(9, 1);
        wait_arq("R7");
        for (int i = 0; i <= g_len; i++) tx[i] = clean[i];
        push_reads("R7");
        send_tx();
        wait_rd();
        read_all();

        // R9: group longer than the buffer -> immediate go-back
        build(10, 8);
        push_arq(2'd2, 0, "R9");
        send_tx();
        wait_arq("R9");
        build(3, 9);
        push_reads("R9");
        send_tx();
        wait_rd();
        read_all();

        repeat (4) @(negedge clk);
        check(exp_arq_q.size() == 0, "R4", "all requests seen", exp_arq_q.size(), 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL R12 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule